// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home node for a small group of cache lines. It keeps the first-level copies of those lines coherent across up to 32 client caches. Each line has a directory entry with three parts: a presence vector holding one bit per client, an exclusive flag that says whether the single holder may write, and a written flag that records that the line has been modified. A client copy is always in one of three states: invalid, shared (read-only) or exclusive (read-write).

Clients send three kinds of request: read-miss, write-miss (which also covers a write to a shared copy) and replace (eviction). The controller decides which other clients must be probed. There are three probe kinds: invalidate, write-back, and write-back-plus-invalidate. The controller sends the probes one per cycle and collects the acknowledgements. Only then does it update the directory and answer the requester.

The controller works on one transaction at a time. It holds off new requests until the current one has answered. A combinational peek port exposes any line's directory entry to neighbouring home logic, for example eviction or refill.

Top module: `dirhome_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and prb_valid are 0, and every directory entry has no holders, exclusive flag 0 and written flag 0.
- R2: A read request (kind 0) to a line that no other client holds exclusive sends no probe. It answers with response kind 0 and adds the requester to the holders. Existing holders are kept and the exclusive flag is 0.
- R3: A write request (kind 1) to a line with shared holders sends one invalidate probe (kind 0) to each holder other than the requester. Probes go out one per cycle, in ascending client number, and each carries the request's line. No probe goes to the requester.
- R4: A write request to a line that another client holds exclusive sends exactly one probe. Its kind is 2 (write back and invalidate) and it goes to that owner.
- R5: The write response (kind 1) is not given until every probed client has acknowledged with the probe's own kind. After it, the requester is the only holder, the exclusive flag is 1 and the written flag is 1.
- R6: A read request to a line that another client holds exclusive sends one probe of kind 1 (write back, keep copy) to the owner. After the acknowledgement the response is kind 0. The holders are then the owner and the requester, the exclusive flag is 0 and the written flag is unchanged.
- R7: A replace request (kind 2) sends no probe and answers with response kind 2. It clears the requester's presence bit. The exclusive flag clears when no holder remains, and the written flag is unchanged.
- R8: Only one transaction is in progress at a time. req_ready is 0 from the cycle after acceptance through the response cycle and is 1 the cycle after the response. A request presented meanwhile stays unaccepted.
- R9: An acknowledgement is ignored if its kind differs from the outstanding probe kind, or if it comes from a client that owes no acknowledgement.
- R10: A directory update changes only the entry of the transaction's own line.
- R11: Every response carries the requester's client number and line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request accepted when both high |
| req_kind | input | 2 | 0 read-miss, 1 write-miss, 2 replace (3 acts as replace) |
| req_client | input | 5 | Requesting client number |
| req_line | input | 3 | Line number |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_kind | output | 2 | Same code as the request kind being answered |
| rsp_client | output | 5 | Client the response goes to |
| rsp_line | output | 3 | Line the response refers to |
| prb_valid | output | 1 | Probe issued this cycle |
| prb_kind | output | 2 | 0 invalidate, 1 write back, 2 write back and invalidate |
| prb_client | output | 5 | Probed client |
| prb_line | output | 3 | Probed line |
| ack_valid | input | 1 | Probe acknowledgement present |
| ack_kind | input | 2 | Kind of probe being acknowledged |
| ack_client | input | 5 | Acknowledging client |
| peek_line | input | 3 | Line selected for the peek port |
| peek_holders | output | 32 | Presence vector of the peeked line |
| peek_excl | output | 1 | Exclusive flag of the peeked line |
| peek_written | output | 1 | Written flag of the peeked line |

## Verification
The hardest case to reach is the window in which every probe has gone out but acknowledgements are still owed. In that window the response must stay withheld, incoming requests must stay unaccepted, and stray acknowledgements must be ignored. The bench first builds a line with three sharers. It then issues a write and lets the probes drain without answering them. Next it feeds in an acknowledgement of the wrong kind and one from a client that owes nothing, and only then answers the real probes one at a time, watching for the response exactly one cycle after the last acknowledgement. The exclusive-owner cases reuse the state that this sequence leaves behind.

// File: rtl/dirhome_pkg.sv
package dirhome_pkg;
   // request kinds; a response reuses the code of the request it answers
   localparam logic [1:0] K_READ  = 2'd0;
   localparam logic [1:0] K_WRITE = 2'd1;
   localparam logic [1:0] K_EVICT = 2'd2;
   // probe kinds; an acknowledgement repeats the probe's code
   localparam logic [1:0] P_INV   = 2'd0;
   localparam logic [1:0] P_WB    = 2'd1;
   localparam logic [1:0] P_INVWB = 2'd2;

   typedef enum logic [1:0] {S_IDLE, S_PROBE, S_DONE} home_st_e;
endpackage

// File: rtl/dirhome_pick.sv
module dirhome_pick #(
   parameter int N = 32,
   localparam int CW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [CW-1:0] idx
);
   // lowest set bit wins, so probes leave in ascending client order
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = CW'(i);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/dirhome_store.sv
module dirhome_store #(
   parameter int NCLI  = 32,
   parameter int NLINE = 8,
   localparam int LW = (NLINE > 1) ? $clog2(NLINE) : 1,
   localparam int EW = NCLI + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] rd_line,
   output logic [EW-1:0] rd_ent,
   input  logic [LW-1:0] pk_line,
   output logic [EW-1:0] pk_ent,
   input  logic          wr_en,
   input  logic [LW-1:0] wr_line,
   input  logic [EW-1:0] wr_ent
);
   // entry layout: {written, exclusive, presence[NCLI-1:0]}
   logic [EW-1:0] ent_all [NLINE];

   for (genvar l = 0; l < NLINE; l++) begin : g_line
      logic [EW-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             ent_q <= '0;
         else if (wr_en && wr_line == LW'(l))    ent_q <= wr_ent;
      end
      assign ent_all[l] = ent_q;
   end

   assign rd_ent = ent_all[rd_line];
   assign pk_ent = ent_all[pk_line];

   // R10
   wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ent_all[$past(wr_line)] == $past(wr_ent));
endmodule

// File: rtl/dirhome_ctrl.sv
module dirhome_ctrl
   import dirhome_pkg::*;
#(
   parameter int NCLI  = 32,
   parameter int NLINE = 8,
   localparam int CW = $clog2(NCLI),
   localparam int LW = (NLINE > 1) ? $clog2(NLINE) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [1:0]      req_kind,
   input  logic [CW-1:0]   req_client,
   input  logic [LW-1:0]   req_line,
   output logic            rsp_valid,
   output logic [1:0]      rsp_kind,
   output logic [CW-1:0]   rsp_client,
   output logic [LW-1:0]   rsp_line,
   output logic            prb_valid,
   output logic [1:0]      prb_kind,
   output logic [CW-1:0]   prb_client,
   output logic [LW-1:0]   prb_line,
   input  logic            ack_valid,
   input  logic [1:0]      ack_kind,
   input  logic [CW-1:0]   ack_client,
   input  logic [LW-1:0]   peek_line,
   output logic [NCLI-1:0] peek_holders,
   output logic            peek_excl,
   output logic            peek_written
);
   localparam int EW = NCLI + 2;

   initial begin
      prm_ncli_chk: assert (NCLI >= 2 && NCLI <= 32)
         else $error("NCLI must lie in 2..32");
      prm_nline_chk: assert (NLINE >= 2 && (NLINE & (NLINE - 1)) == 0)
         else $error("NLINE must be a power of two, at least 2");
   end

   home_st_e      st_q;
   logic [1:0]    kind_q, pkind_q;
   logic [CW-1:0] cli_q;
   logic [LW-1:0] line_q;
   logic [NCLI-1:0] todo_q, wait_q;

   logic [LW-1:0] rd_line;
   logic [EW-1:0] rd_ent, pk_ent, wr_ent;
   logic [NCLI-1:0] rd_vec, req_bit, cur_bit, others, targets;
   logic            rd_excl, rd_wr, accept;
   logic [1:0]      pk_sel;

   assign accept  = (st_q == S_IDLE) && req_valid;
   assign rd_line = (st_q == S_IDLE) ? req_line : line_q;
   assign rd_vec  = rd_ent[NCLI-1:0];
   assign rd_excl = rd_ent[NCLI];
   assign rd_wr   = rd_ent[NCLI+1];
   assign req_bit = NCLI'(1) << req_client;
   assign cur_bit = NCLI'(1) << cli_q;
   assign others  = rd_vec & ~req_bit;

   // probe plan for a request being accepted
   always_comb begin
      targets = '0;
      pk_sel  = P_INV;
      case (req_kind)
         K_READ: if (rd_excl) begin
            targets = others;
            pk_sel  = P_WB;
         end
         K_WRITE: begin
            targets = others;
            pk_sel  = rd_excl ? P_INVWB : P_INV;
         end
         default: ;
      endcase
   end

   // probe issue and acknowledgement tracking
   logic            pick_any;
   logic [CW-1:0]   pick_idx;
   logic [NCLI-1:0] issued, acked, wait_nx, todo_nx;

   dirhome_pick #(.N(NCLI)) u_pick (
      .vec (todo_q),
      .any (pick_any),
      .idx (pick_idx)
   );

   assign issued  = (st_q == S_PROBE && pick_any) ? (NCLI'(1) << pick_idx) : '0;
   assign acked   = (ack_valid && ack_kind == pkind_q) ? (NCLI'(1) << ack_client) : '0;
   assign wait_nx = (wait_q | issued) & ~acked;
   assign todo_nx = todo_q & ~issued;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         kind_q  <= K_READ;
         pkind_q <= P_INV;
         cli_q   <= '0;
         line_q  <= '0;
         todo_q  <= '0;
         wait_q  <= '0;
      end else begin
         case (st_q)
            S_IDLE: if (accept) begin
               kind_q  <= req_kind;
               cli_q   <= req_client;
               line_q  <= req_line;
               todo_q  <= targets;
               pkind_q <= pk_sel;
               wait_q  <= '0;
               st_q    <= S_PROBE;
            end
            S_PROBE: begin
               todo_q <= todo_nx;
               wait_q <= wait_nx;
               if (todo_nx == '0 && wait_nx == '0) st_q <= S_DONE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   // directory update at completion
   logic [NCLI-1:0] nvec;
   logic            nex, nwr;
   always_comb begin
      case (kind_q)
         K_READ: begin
            nvec = rd_vec | cur_bit;
            nex  = 1'b0;
            nwr  = rd_wr;
         end
         K_WRITE: begin
            nvec = cur_bit;
            nex  = 1'b1;
            nwr  = 1'b1;
         end
         default: begin
            nvec = rd_vec & ~cur_bit;
            nex  = rd_excl && (nvec != '0);
            nwr  = rd_wr;
         end
      endcase
   end
   assign wr_ent = {nwr, nex, nvec};

   dirhome_store #(.NCLI(NCLI), .NLINE(NLINE)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_line (rd_line),
      .rd_ent  (rd_ent),
      .pk_line (peek_line),
      .pk_ent  (pk_ent),
      .wr_en   (st_q == S_DONE),
      .wr_line (line_q),
      .wr_ent  (wr_ent)
   );

   assign req_ready    = (st_q == S_IDLE);
   assign rsp_valid    = (st_q == S_DONE);
   assign rsp_kind     = kind_q;
   assign rsp_client   = cli_q;
   assign rsp_line     = line_q;
   assign prb_valid    = (st_q == S_PROBE) && pick_any;
   assign prb_kind     = pkind_q;
   assign prb_client   = pick_idx;
   assign prb_line     = line_q;
   assign peek_holders = pk_ent[NCLI-1:0];
   assign peek_excl    = pk_ent[NCLI];
   assign peek_written = pk_ent[NCLI+1];

   // R8
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R8
   idle_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> req_ready);
   // R3
   no_self_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prb_valid |-> prb_client != rsp_client);
   // R5
   rsp_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (wait_q == '0 && todo_q == '0));
   // R7
   evict_no_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prb_valid |-> kind_q != K_EVICT);
endmodule

// File: tb/dirhome_ctrl_bench.sv
`timescale 1ns/1ps
module dirhome_ctrl_bench;
   import dirhome_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid, req_ready;
   logic [1:0]  req_kind;
   logic [4:0]  req_client;
   logic [2:0]  req_line;
   logic        rsp_valid;
   logic [1:0]  rsp_kind;
   logic [4:0]  rsp_client;
   logic [2:0]  rsp_line;
   logic        prb_valid;
   logic [1:0]  prb_kind;
   logic [4:0]  prb_client;
   logic [2:0]  prb_line;
   logic        ack_valid;
   logic [1:0]  ack_kind;
   logic [4:0]  ack_client;
   logic [2:0]  peek_line;
   logic [31:0] peek_holders;
   logic        peek_excl, peek_written;

   always #2.5 clk = ~clk;

   dirhome_ctrl #(.NCLI(32), .NLINE(8)) u_dirhome_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_client(req_client), .req_line(req_line),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_client(rsp_client), .rsp_line(rsp_line),
      .prb_valid(prb_valid), .prb_kind(prb_kind), .prb_client(prb_client), .prb_line(prb_line),
      .ack_valid(ack_valid), .ack_kind(ack_kind), .ack_client(ack_client),
      .peek_line(peek_line), .peek_holders(peek_holders),
      .peek_excl(peek_excl), .peek_written(peek_written)
   );

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [31:0] got_mask;
   logic [1:0]  got_pkind;
   logic [4:0]  last_cli;
   int          n_prb;
   bit          kind_mixed, order_bad, line_bad, got_rsp;
   logic [1:0]  r_kind;
   logic [4:0]  r_cli;
   logic [2:0]  r_line;

   function automatic logic [31:0] b(input int c);
      return 32'(1) << c;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] k, input int c, input int l);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_client = c[4:0]; req_line = l[2:0];
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      got_mask = '0; n_prb = 0; kind_mixed = 0; order_bad = 0; line_bad = 0; got_rsp = 0;
      got_pkind = '0; last_cli = '0;
   endtask

   task automatic note_probe(input int l);
      if (n_prb > 0 && prb_kind !== got_pkind) kind_mixed = 1;
      if (n_prb > 0 && prb_client <= last_cli) order_bad = 1;
      if (prb_line !== l[2:0]) line_bad = 1;
      got_pkind = prb_kind;
      last_cli = prb_client;
      got_mask[prb_client] = 1'b1;
      n_prb++;
   endtask

   // acknowledges every probe as soon as it appears
   task automatic run_eager(input logic [1:0] k, input int c, input int l);
      issue(k, c, l);
      for (int i = 0; i < 60 && !got_rsp; i++) begin
         ack_valid = 1'b0;
         if (prb_valid) begin
            note_probe(l);
            ack_valid = 1'b1; ack_kind = prb_kind; ack_client = prb_client;
         end
         if (rsp_valid) begin
            got_rsp = 1; r_kind = rsp_kind; r_cli = rsp_client; r_line = rsp_line;
         end else begin
            @(negedge clk);
         end
      end
      ack_valid = 1'b0;
      check("R8", "response arrived", 64'(got_rsp), 64'd1);
      check("R11", "response client", 64'(r_cli), 64'(c));
      check("R11", "response line", 64'(r_line), 64'(l));
      @(negedge clk);
      check("R8", "ready after response", 64'(req_ready), 64'd1);
   endtask

   task automatic expect_dir(input string req, input int l, input logic [31:0] vec,
                             input bit ex, input bit wr);
      peek_line = l[2:0];
      #1;
      check(req, "holders", 64'(peek_holders), 64'(vec));
      check(req, "exclusive flag", 64'(peek_excl), 64'(ex));
      check(req, "written flag", 64'(peek_written), 64'(wr));
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1", "req_ready", 64'(req_ready), 64'd1);
      check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
      check("R1", "prb_valid", 64'(prb_valid), 64'd0);
      expect_dir("R1", 0, '0, 0, 0);
      expect_dir("R1", 7, '0, 0, 0);
   endtask

   task automatic t_read_share();
      run_eager(K_READ, 3, 2);
      check("R2", "probe count", 64'(n_prb), 64'd0);
      check("R2", "response kind", 64'(r_kind), 64'(K_READ));
      run_eager(K_READ, 9, 2);
      check("R2", "probe count", 64'(n_prb), 64'd0);
      run_eager(K_READ, 30, 2);
      check("R2", "probe count", 64'(n_prb), 64'd0);
      expect_dir("R2", 2, b(3) | b(9) | b(30), 0, 0);
   endtask

   // write to a shared line with acknowledgements held back
   task automatic t_write_held();
      issue(K_WRITE, 9, 2);
      for (int i = 0; i < 8; i++) begin
         if (prb_valid) note_probe(2);
         if (rsp_valid) got_rsp = 1;
         @(negedge clk);
      end
      check("R3", "probed set", 64'(got_mask), 64'(b(3) | b(30)));
      check("R3", "probe kind", 64'(got_pkind), 64'(P_INV));
      check("R3", "ascending order", 64'(order_bad), 64'd0);
      check("R3", "probe line", 64'(line_bad), 64'd0);
      check("R5", "no early response", 64'(got_rsp | rsp_valid), 64'd0);
      check("R8", "busy while waiting", 64'(req_ready), 64'd0);
      // R8: a second request waits unaccepted
      req_valid = 1'b1; req_kind = K_READ; req_client = 5'd4; req_line = 3'd3;
      ack_valid = 1'b1; ack_kind = P_WB; ack_client = 5'd3;
      @(negedge clk);
      ack_kind = P_INV; ack_client = 5'd5;
      @(negedge clk);
      ack_valid = 1'b0;
      @(negedge clk);
      check("R9", "stray acks ignored", 64'(rsp_valid), 64'd0);
      check("R8", "held request not taken", 64'(req_ready), 64'd0);
      req_valid = 1'b0;
      ack_valid = 1'b1; ack_kind = P_INV; ack_client = 5'd3;
      @(negedge clk);
      ack_valid = 1'b0;
      check("R5", "one ack still owed", 64'(rsp_valid), 64'd0);
      ack_valid = 1'b1; ack_kind = P_INV; ack_client = 5'd30;
      @(negedge clk);
      ack_valid = 1'b0;
      check("R5", "response after last ack", 64'(rsp_valid), 64'd1);
      check("R5", "response kind", 64'(rsp_kind), 64'(K_WRITE));
      check("R11", "response client", 64'(rsp_client), 64'd9);
      @(negedge clk);
      check("R8", "ready after response", 64'(req_ready), 64'd1);
      expect_dir("R5", 2, b(9), 1, 1);
      expect_dir("R10", 3, '0, 0, 0);
   endtask

   task automatic t_write_owner();
      run_eager(K_WRITE, 17, 2);
      check("R4", "probed set", 64'(got_mask), 64'(b(9)));
      check("R4", "probe count", 64'(n_prb), 64'd1);
      check("R4", "probe kind", 64'(got_pkind), 64'(P_INVWB));
      check("R5", "response kind", 64'(r_kind), 64'(K_WRITE));
      expect_dir("R5", 2, b(17), 1, 1);
   endtask

   task automatic t_read_owner();
      run_eager(K_READ, 0, 2);
      check("R6", "probed set", 64'(got_mask), 64'(b(17)));
      check("R6", "probe count", 64'(n_prb), 64'd1);
      check("R6", "probe kind", 64'(got_pkind), 64'(P_WB));
      check("R6", "response kind", 64'(r_kind), 64'(K_READ));
      expect_dir("R6", 2, b(0) | b(17), 0, 1);
   endtask

   task automatic t_evict();
      run_eager(K_EVICT, 17, 2);
      check("R7", "probe count", 64'(n_prb), 64'd0);
      check("R7", "response kind", 64'(r_kind), 64'(K_EVICT));
      expect_dir("R7", 2, b(0), 0, 1);
      run_eager(K_EVICT, 0, 2);
      expect_dir("R7", 2, '0, 0, 1);
      run_eager(K_WRITE, 31, 4);
      check("R5", "no probes on empty line", 64'(n_prb), 64'd0);
      expect_dir("R5", 4, b(31), 1, 1);
      run_eager(K_EVICT, 31, 4);
      check("R7", "probe count", 64'(n_prb), 64'd0);
      expect_dir("R7", 4, '0, 0, 1);
   endtask

   task automatic t_isolate();
      run_eager(K_WRITE, 1, 6);
      check("R3", "kind mix", 64'(kind_mixed), 64'd0);
      expect_dir("R10", 6, b(1), 1, 1);
      expect_dir("R10", 3, '0, 0, 0);
      expect_dir("R10", 5, '0, 0, 0);
      expect_dir("R10", 2, '0, 0, 1);
   endtask

   initial begin
      req_valid = 1'b0; req_kind = '0; req_client = '0; req_line = '0;
      ack_valid = 1'b0; ack_kind = '0; ack_client = '0; peek_line = '0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_read_share();
      t_write_held();
      t_write_owner();
      t_read_owner();
      t_evict();
      t_isolate();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL R8 watchdog actual=hung expected=complete");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule